// File: doc/BRIEF.md
# Carry Chain Length Classifier

This block sits beside an n-bit adder and scores every operand pair presented to it. A bit position propagates a carry when exactly one of its two operand bits is set. The block looks for the longest unbroken run of such positions, a span in which an incoming carry would ripple straight through. It reports where that run begins and ends and how long it is. The length is the pair's weight. The score is a measure of how close the pair comes to the adder's worst-case carry path.

Each scored pair also increments one of a set of equal-width weight bins. Over a workload, the bins build up a distribution of weights that shows how often long carry paths actually occur. A synchronous clear empties the bins. Any bin can be read back through a small select-and-read port. The block only observes operands: it computes no sum and does not alter the adder.

Top module: `chain_classifier`

## Requirements
- R1: Bit k propagates when op_a[k] XOR op_b[k] is 1. A chain is a maximal run of consecutive propagating bits.
- R2: out_weight equals the length of the longest chain of the pair, from 0 to WIDTH.
- R3: out_start and out_finish are the bit indices (bit 0 = LSB) of the lowest and highest bit of that chain, with out_finish - out_start + 1 = out_weight.
- R4: When several chains share the longest length, the one with the lowest start bit is reported.
- R5: A pair with no propagating bit gives out_weight 0, out_start 0, out_finish 0 and out_none 1. Any other pair gives out_none 0.
- R6: Results appear on the clock edge after the one that samples in_valid high, and out_valid is high for exactly that cycle. Without in_valid, the result outputs hold their values.
- R7: With SPAN = WIDTH/NUM_BINS, bin b counts weights w with b*SPAN < w <= (b+1)*SPAN. Weight 0 is counted in bin 0. Each valid pair adds one to its bin.
- R8: A bin counter stops at its all-ones value (2^COUNT_W - 1) and never wraps.
- R9: When clr_bins is high at an edge, every counter reads 0 after that edge. A pair sampled at the same edge still produces its result but is not counted.
- R10: rd_count returns, one edge after rd_bin is sampled, the count that bin held before that edge.
- R11: After reset, out_valid, the result outputs and all bin counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_bins | input | 1 | Synchronous clear of all weight bins |
| in_valid | input | 1 | Operand pair valid strobe |
| op_a | input | WIDTH | First adder operand |
| op_b | input | WIDTH | Second adder operand |
| rd_bin | input | BIN_W | Bin selected for readback |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_weight | output | WEIGHT_W | Length of the longest chain |
| out_start | output | IDX_W | Lowest bit of the longest chain |
| out_finish | output | IDX_W | Highest bit of the longest chain |
| out_none | output | 1 | No propagating bit in the pair |
| rd_count | output | COUNT_W | Registered count of the selected bin |

## Verification
The assertions assume that rst is held high for at least one edge before any other activity and that control inputs never carry unknown values. After that, they rely only on the block's own registers. The monotonic-counter checks assume that only a clear or reset lowers a bin, so the stimulus never asserts rst after the start. All inputs change on the falling clock edge. A small configuration (8-bit operands, four bins, 15-bit counters) lets the stimulus sweep every one of the 65536 operand pairs back to back. That sweep fills the bin holding the short weights past its ceiling, while the other bins keep exact counts.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // Bits needed to index n items, never less than one.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Bits needed to hold the value n itself.
  function automatic int val_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cc_run_scan.sv
module cc_run_scan #(
  parameter int WIDTH    = 32,
  parameter int IDX_W    = 5,
  parameter int WEIGHT_W = 6
) (
  input  logic [WIDTH-1:0]    prop,
  output logic [WEIGHT_W-1:0] weight,
  output logic [IDX_W-1:0]    start,
  output logic [IDX_W-1:0]    finish,
  output logic                none
);
  // Length of the propagating run that ends at each bit position.
  logic [WEIGHT_W-1:0] run_len [WIDTH];

  for (genvar k = 0; k < WIDTH; k++) begin : g_run
    if (k == 0) begin : g_lsb
      assign run_len[k] = prop[k] ? WEIGHT_W'(1) : '0;
    end else begin : g_up
      assign run_len[k] = prop[k] ? run_len[k-1] + WEIGHT_W'(1) : '0;
    end
  end

  logic [WEIGHT_W-1:0] best_len;
  logic [IDX_W-1:0]    best_end;

  // Strictly greater keeps the earliest-ending run on a tie (R4).
  always_comb begin
    best_len = '0;
    best_end = '0;
    for (int k = 0; k < WIDTH; k++) begin
      if (run_len[k] > best_len) begin
        best_len = run_len[k];
        best_end = IDX_W'(k);
      end
    end
  end

  assign none   = (best_len == '0);
  assign weight = best_len;
  assign finish = none ? '0 : best_end;
  assign start  = none ? '0 : best_end - IDX_W'(best_len) + IDX_W'(1);
endmodule

// File: rtl/cc_bin_map.sv
module cc_bin_map #(
  parameter int WIDTH    = 32,
  parameter int NUM_BINS = 4,
  parameter int WEIGHT_W = 6,
  parameter int BIN_W    = 2
) (
  input  logic [WEIGHT_W-1:0] weight,
  output logic [BIN_W-1:0]    bin
);
  localparam int SPAN = WIDTH / NUM_BINS;

  always_comb begin
    bin = '0;
    for (int b = 1; b < NUM_BINS; b++) begin
      if (int'(weight) > b * SPAN) bin = BIN_W'(b);
    end
  end

  // R7: a nonzero weight lands inside its bin's bounds.
  always_comb begin
    if (weight != '0) begin
      a_r7_bin_bounds : assert (int'(weight) > int'(bin) * SPAN &&
                                int'(weight) <= (int'(bin) + 1) * SPAN);
    end
  end
endmodule

// File: rtl/cc_hist_bank.sv
module cc_hist_bank #(
  parameter int NUM_BINS = 4,
  parameter int COUNT_W  = 32,
  parameter int BIN_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               inc_en,
  input  logic [BIN_W-1:0]   inc_bin,
  input  logic [BIN_W-1:0]   rd_bin,
  output logic [COUNT_W-1:0] rd_count
);
  logic [COUNT_W-1:0] cnt [NUM_BINS];

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cnt[b] <= '0;
      end else if (inc_en && inc_bin == BIN_W'(b) && cnt[b] != '1) begin
        cnt[b] <= cnt[b] + COUNT_W'(1);
      end
    end

    // R8: a bin never falls except through clear or reset.
    a_r8_no_wrap : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(clr)) |-> cnt[b] >= $past(cnt[b]));

    // R7: a bin grows by at most one per edge.
    a_r7_step_one : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(clr)) |-> (cnt[b] - $past(cnt[b])) <= COUNT_W'(1));

    // R9: clear empties the bin on the next edge.
    a_r9_clear : assert property (@(posedge clk) disable iff (rst)
      clr |=> cnt[b] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_count <= '0;
    end else if (int'(rd_bin) < NUM_BINS) begin
      rd_count <= cnt[rd_bin];
    end else begin
      rd_count <= '0;
    end
  end
endmodule

// File: rtl/chain_classifier.sv
module chain_classifier
  import cc_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int NUM_BINS = 4,
  parameter int COUNT_W  = 32,
  parameter int IDX_W    = idx_bits(WIDTH),
  parameter int WEIGHT_W = val_bits(WIDTH),
  parameter int BIN_W    = idx_bits(NUM_BINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_bins,
  input  logic                in_valid,
  input  logic [WIDTH-1:0]    op_a,
  input  logic [WIDTH-1:0]    op_b,
  input  logic [BIN_W-1:0]    rd_bin,
  output logic                out_valid,
  output logic [WEIGHT_W-1:0] out_weight,
  output logic [IDX_W-1:0]    out_start,
  output logic [IDX_W-1:0]    out_finish,
  output logic                out_none,
  output logic [COUNT_W-1:0]  rd_count
);
  logic [WIDTH-1:0]    prop;
  logic [WEIGHT_W-1:0] s_weight;
  logic [IDX_W-1:0]    s_start, s_finish;
  logic                s_none;
  logic [BIN_W-1:0]    s_bin;

  assign prop = op_a ^ op_b;

  cc_run_scan #(.WIDTH(WIDTH), .IDX_W(IDX_W), .WEIGHT_W(WEIGHT_W)) u_scan (
    .prop(prop), .weight(s_weight), .start(s_start),
    .finish(s_finish), .none(s_none)
  );

  cc_bin_map #(.WIDTH(WIDTH), .NUM_BINS(NUM_BINS), .WEIGHT_W(WEIGHT_W),
               .BIN_W(BIN_W)) u_map (
    .weight(s_weight), .bin(s_bin)
  );

  cc_hist_bank #(.NUM_BINS(NUM_BINS), .COUNT_W(COUNT_W), .BIN_W(BIN_W)) u_hist (
    .clk(clk), .rst(rst), .clr(clr_bins), .inc_en(in_valid && !clr_bins),
    .inc_bin(s_bin), .rd_bin(rd_bin), .rd_count(rd_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_weight <= '0;
      out_start  <= '0;
      out_finish <= '0;
      out_none   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_weight <= s_weight;
        out_start  <= s_start;
        out_finish <= s_finish;
        out_none   <= s_none;
      end
    end
  end

  // R6: out_valid follows in_valid by exactly one edge.
  a_r6_valid_follows : assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r6_valid_quiet : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R6: results hold while no pair arrives.
  a_r6_hold : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_weight) && $stable(out_start) && $stable(out_finish));
  // R5: an empty pair reports zero bounds and weight.
  a_r5_none_zero : assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_none) |-> (out_weight == '0 && out_start == '0 && out_finish == '0));
  // R3: reported bounds agree with the weight.
  a_r3_bounds_len : assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_none) |->
      (int'(out_finish) - int'(out_start) + 1 == int'(out_weight) && out_weight != '0));
endmodule

// File: tb/test_chain_classifier.sv
`timescale 1ns/1ps
module test_chain_classifier;
  localparam int W  = 8;
  localparam int NB = 4;
  localparam int CW = 15;
  localparam int SPAN = W / NB;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_bins = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [1:0] rd_bin = '0;
  logic out_valid, out_none;
  logic [3:0] out_weight;
  logic [2:0] out_start, out_finish;
  logic [CW-1:0] rd_count;

  int checks = 0;
  int errors = 0;
  int hist [NB];

  always #2 clk = ~clk;

  chain_classifier #(.WIDTH(W), .NUM_BINS(NB), .COUNT_W(CW)) i_chain_classifier (
    .clk(clk), .rst(rst), .clr_bins(clr_bins), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .rd_bin(rd_bin), .out_valid(out_valid),
    .out_weight(out_weight), .out_start(out_start), .out_finish(out_finish),
    .out_none(out_none), .rd_count(rd_count)
  );

  // Behavioural scan of the propagate vector, LSB upward.
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                       output int w, output int s, output int f);
    logic [W-1:0] p;
    int run_s, run_n;
    p = a ^ b;
    w = 0; s = 0; f = 0; run_s = 0; run_n = 0;
    for (int k = 0; k < W; k++) begin
      if (p[k]) begin
        if (run_n == 0) run_s = k;
        run_n++;
        if (run_n > w) begin w = run_n; s = run_s; f = k; end
      end else begin
        run_n = 0;
      end
    end
  endtask

  function automatic int bin_of(input int w);
    return (w == 0) ? 0 : (w - 1) / SPAN;
  endfunction

  task automatic check_result(input logic [W-1:0] a, input logic [W-1:0] b,
                              input string tag);
    int w, s, f;
    model(a, b, w, s, f);
    checks++;
    if (!out_valid || int'(out_weight) != w || int'(out_start) != s ||
        int'(out_finish) != f || out_none != (w == 0)) begin
      errors++;
      $display("FAIL %s a=%h b=%h got v=%0d w=%0d s=%0d f=%0d n=%0d exp v=1 w=%0d s=%0d f=%0d n=%0d",
               tag, a, b, out_valid, out_weight, out_start, out_finish, out_none,
               w, s, f, (w == 0));
    end
  endtask

  task automatic check_bin(input int b, input int exp, input string tag);
    @(negedge clk);
    rd_bin = 2'(b);
    @(negedge clk);
    checks++;
    if (int'(rd_count) != exp) begin
      errors++;
      $display("FAIL %s bin=%0d got %0d exp %0d", tag, b, rd_count, exp);
    end
  endtask

  task automatic one_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                          input string tag);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(a, b, tag);
  endtask

  task automatic clear_bins();
    @(negedge clk);
    clr_bins = 1'b1;
    @(negedge clk);
    clr_bins = 1'b0;
    for (int b = 0; b < NB; b++) hist[b] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R6 got hung exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) hist[b] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    checks++;
    if (out_valid || out_weight != 0 || out_start != 0 || out_finish != 0 || out_none) begin
      errors++;
      $display("FAIL R11 outputs after reset got v=%0d w=%0d exp all zero", out_valid, out_weight);
    end
    for (int b = 0; b < NB; b++) check_bin(b, 0, "R11");

    // Directed patterns.
    one_pair(8'hFF, 8'h00, "R2 all-ones propagate");
    one_pair(8'h55, 8'h00, "R1 alternating");
    one_pair(8'hAA, 8'h00, "R1 alternating high");
    one_pair(8'h33, 8'h00, "R4 tie low start");
    one_pair(8'h66, 8'h00, "R4 tie start one");
    one_pair(8'h5A, 8'h5A, "R5 no chain");
    one_pair(8'hF0, 8'h0E, "R3 bounds mixed");
    one_pair(8'h80, 8'h00, "R3 single msb");

    // R6: out_valid drops and results hold without a new pair.
    @(negedge clk);
    checks++;
    if (out_valid || out_weight != 1 || out_start != 7 || out_finish != 7) begin
      errors++;
      $display("FAIL R6 idle got v=%0d w=%0d s=%0d exp v=0 w=1 s=7", out_valid, out_weight, out_start);
    end

    // R9: clear wins over a pair in the same cycle.
    @(negedge clk);
    clr_bins = 1'b1; in_valid = 1'b1; op_a = 8'hFF; op_b = 8'h00;
    @(negedge clk);
    clr_bins = 1'b0; in_valid = 1'b0;
    check_result(8'hFF, 8'h00, "R9 result during clear");
    for (int b = 0; b < NB; b++) check_bin(b, 0, "R9");
    for (int b = 0; b < NB; b++) hist[b] = 0;

    // Exhaustive back-to-back sweep of every pair (R1 R2 R3 R4 R5 R7 R8).
    for (int i = 0; i < (1 << (2 * W)); i++) begin
      logic [W-1:0] pa, pb;
      int w, s, f;
      @(negedge clk);
      if (i > 0) check_result(op_a, op_b, "R2,R3,R4,R5 sweep");
      pa = W'(i >> W);
      pb = W'(i);
      in_valid = 1'b1; op_a = pa; op_b = pb;
      model(pa, pb, w, s, f);
      if (hist[bin_of(w)] < CMAX) hist[bin_of(w)]++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_result(op_a, op_b, "R2,R3,R4,R5 sweep");

    // R7 exact bin counts, R8 saturation of the crowded bin, R10 readback.
    check_bin(0, hist[0], "R8 saturated bin");
    for (int b = 1; b < NB; b++) check_bin(b, hist[b], "R7 bin count");
    one_pair(8'hFF, 8'h00, "R2 after sweep");
    check_bin(3, (hist[3] < CMAX) ? hist[3] + 1 : CMAX, "R10 readback after increment");
    one_pair(8'h00, 8'h00, "R5 zero pair");
    check_bin(0, CMAX, "R8 stays at ceiling");

    clear_bins();
    one_pair(8'h07, 8'h00, "R7 weight three");
    check_bin(1, 1, "R7 bin one");
    check_bin(0, 0, "R7 bin zero untouched");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule